// File: doc/BRIEF.md
# Serial EEPROM Single-Word Erase Sequencer

This block is the master side of a three-wire serial EEPROM link. It performs exactly one operation: erasing one word, which makes every bit of that word read as 1. A client raises `req` for one clock with a word address on `addr`. The sequencer then drives chip select (`mwCs`), a divided serial clock (`mwSck`) and serial data (`mwDi`) to send the erase command. After the command it holds chip select low for a minimum time and raises it again. It then watches the device's data-out line (`mwDo`), which acts as a ready/busy flag while the self-timed programming cycle runs.

When the flag reports ready, the sequencer clocks out a single 1 bit and drops chip select. This clears the flag on the device. It then pulses `done`. If ready does not arrive within `POLL_LIMIT` system clocks after programming began, it pulses `err` instead and goes back to idle.

Two device variants are supported through `EARLY_START`. On the standard variant (0), programming starts when chip select falls after the last address bit. On the alternate variant (1), programming starts on the rising serial-clock edge that samples the last address bit. The timeout window is counted from whichever start point applies.

Top module: `mw_erase_seq`

## Requirements
- R1: Each accepted request sends `3+ADDR_W` bits while `mwCs` is high, sampled on rising `mwSck` edges, in this order: a 1 as the start bit, then the opcode bits 1 and 1, then `addr` from its most significant bit down to bit 0.
- R2: `mwSck` has a period of `2*CLK_DIV` system clocks during the frame. `mwDi` never changes while `mwSck` is high.
- R3: After the frame, `mwCs` stays low for exactly `CS_LOW_CLKS` system clocks before it rises for the status check.
- R4: While `mwCs` is high in the status check, a synchronised `mwDo` of 0 keeps the sequencer polling. A 1 means ready. `done` never comes before the device reports ready.
- R5: On ready, the sequencer sends one `mwSck` pulse with `mwDi`=1, then drops `mwCs` in the same cycle that `done` pulses high for one clock.
- R6: `err` pulses exactly `POLL_LIMIT` system clocks after the programming start point. With `EARLY_START`=0 that point is the `mwCs` fall. With `EARLY_START`=1 it is the last address bit's rising `mwSck` edge, which comes `CLK_DIV` clocks before `mwCs` falls.
- R7: `busy` is high from the clock after an accepted `req` until the cycle of `done` or `err`. A `req` while busy is ignored and sends no second frame.
- R8: After reset, `mwCs`, `mwSck`, `mwDi`, `busy`, `done` and `err` are all 0.
- R9: `mwSck` is low whenever `mwCs` is low.
- R10: `done` and `err` are never high together, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Erase request, one-clock pulse |
| addr | input | ADDR_W | Word address to erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Erase completed, one-clock pulse |
| err | output | 1 | Ready not seen in time, one-clock pulse |
| mwCs | output | 1 | Chip select to the EEPROM |
| mwSck | output | 1 | Serial clock to the EEPROM |
| mwDi | output | 1 | Serial data to the EEPROM |
| mwDo | input | 1 | Serial data / ready-busy flag from the EEPROM |

## Verification
The minimum-low-time check on the status rise of `mwCs` assumes that the client leaves at least `CS_LOW_CLKS` idle clocks between one operation's end and the next request. The check does not apply to the rise at frame start, and the bench always waits well beyond that gap. The assertions also assume that `mwDo` reads 0 whenever chip select is low or the device is not in its status phase. The bench's device model drives it that way, so the synchroniser is always clear when polling begins. They further take `CS_LOW_CLKS` to be at least 3, so the stale flag drains before chip select rises.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

  localparam logic       START_BIT    = 1'b1;
  localparam logic [1:0] OPCODE_ERASE = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CSLOW,
    ST_POLL,
    ST_CLEAR
  } mweState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic divClr;
    logic sckRise;
    logic sckFall;
    logic shiftNext;
    logic csHigh;
    logic csLow;
    logic diLow;
    logic diHigh;
    logic lowClr;
    logic timerStart;
    logic timerStop;
  } mweStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic tick;
    logic sckHigh;
    logic lastBit;
    logic frameDone;
    logic lowDone;
    logic timeout;
    logic ready;
  } mweStatus_t;

endpackage

// File: rtl/mwe_datapath.sv
module mwe_datapath
  import mwe_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int CLK_DIV     = 4,
  parameter int CS_LOW_CLKS = 25,
  parameter int POLL_LIMIT  = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mwDo,
  input  mweStrobe_t        stb,
  output mweStatus_t        st,
  output logic              mwCs,
  output logic              mwSck,
  output logic              mwDi
);

  localparam int FRAME_W = 3 + ADDR_W;
  localparam int REST_W  = FRAME_W - 1;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int DIV_W   = $clog2(CLK_DIV + 1);
  localparam int LOW_W   = $clog2(CS_LOW_CLKS + 1);
  localparam int TMR_W   = $clog2(POLL_LIMIT + 1);

  logic [DIV_W-1:0]  divCnt;
  logic [REST_W-1:0] restBits;
  logic [BIT_W-1:0]  bitCnt;
  logic [LOW_W-1:0]  lowCnt;
  logic [TMR_W-1:0]  timer;
  logic              timing;
  logic [1:0]        doSync;
  logic              csReg, sckReg, diReg;

  // serial clock divider: one tick per half period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                divCnt <= '0;
    else if (stb.divClr)                      divCnt <= '0;
    else if (divCnt == DIV_W'(CLK_DIV - 1))   divCnt <= '0;
    else                                      divCnt <= divCnt + 1'b1;
  end

  // frame shifter; start bit goes straight to diReg on load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      restBits <= '0;
      bitCnt   <= '0;
    end else if (stb.load) begin
      restBits <= {OPCODE_ERASE, addr};
      bitCnt   <= BIT_W'(FRAME_W);
    end else begin
      if (stb.shiftNext) restBits <= {restBits[REST_W-2:0], 1'b0};
      if (stb.sckRise && bitCnt != '0) bitCnt <= bitCnt - 1'b1;
    end
  end

  // pin registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csReg  <= 1'b0;
      sckReg <= 1'b0;
      diReg  <= 1'b0;
    end else begin
      if (stb.csHigh)      csReg <= 1'b1;
      else if (stb.csLow)  csReg <= 1'b0;
      if (stb.sckRise)     sckReg <= 1'b1;
      else if (stb.sckFall) sckReg <= 1'b0;
      if (stb.load || stb.diHigh) diReg <= START_BIT;
      else if (stb.diLow)         diReg <= 1'b0;
      else if (stb.shiftNext)     diReg <= restBits[REST_W-1];
    end
  end

  // chip-select low-time counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   lowCnt <= '0;
    else if (stb.lowClr)                         lowCnt <= '0;
    else if (lowCnt != LOW_W'(CS_LOW_CLKS - 1))  lowCnt <= lowCnt + 1'b1;
  end

  // programming-cycle timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timing <= 1'b0;
      timer  <= '0;
    end else if (stb.timerStart) begin
      timing <= 1'b1;
      timer  <= '0;
    end else if (stb.timerStop) begin
      timing <= 1'b0;
    end else if (timing && timer != TMR_W'(POLL_LIMIT - 1)) begin
      timer <= timer + 1'b1;
    end
  end

  // ready/busy synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doSync <= 2'b00;
    else       doSync <= {doSync[0], mwDo};
  end

  always_comb begin
    st.tick      = (divCnt == DIV_W'(CLK_DIV - 1));
    st.sckHigh   = sckReg;
    st.lastBit   = (bitCnt == BIT_W'(1));
    st.frameDone = (bitCnt == '0);
    st.lowDone   = (lowCnt == LOW_W'(CS_LOW_CLKS - 1));
    st.timeout   = timing && (timer == TMR_W'(POLL_LIMIT - 1));
    st.ready     = doSync[1];
  end

  assign mwCs  = csReg;
  assign mwSck = sckReg;
  assign mwDi  = diReg;

endmodule

// File: rtl/mwe_control.sv
module mwe_control
  import mwe_pkg::*;
#(
  parameter int EARLY_START = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  mweStatus_t st,
  output mweStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       err
);

  mweState_t state, stateNext;
  logic      doneNext, errNext;
  logic      startOnRise, startOnFall;

  // variant selects where the programming-cycle timer begins
  generate
    if (EARLY_START != 0) begin : g_early
      assign startOnRise = 1'b1;
      assign startOnFall = 1'b0;
    end else begin : g_std
      assign startOnRise = 1'b0;
      assign startOnFall = 1'b1;
    end
  endgenerate

  always_comb begin
    stb       = '0;
    stateNext = state;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          stb.load   = 1'b1;
          stb.divClr = 1'b1;
          stb.csHigh = 1'b1;
          stateNext  = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (st.tick) begin
          if (!st.sckHigh) begin
            stb.sckRise = 1'b1;
            if (startOnRise && st.lastBit) stb.timerStart = 1'b1;
          end else begin
            stb.sckFall = 1'b1;
            if (st.frameDone) begin
              stb.csLow  = 1'b1;
              stb.diLow  = 1'b1;
              stb.lowClr = 1'b1;
              if (startOnFall) stb.timerStart = 1'b1;
              stateNext = ST_CSLOW;
            end else begin
              stb.shiftNext = 1'b1;
            end
          end
        end
      end
      ST_CSLOW: begin
        if (st.timeout) begin
          stb.timerStop = 1'b1;
          errNext       = 1'b1;
          stateNext     = ST_IDLE;
        end else if (st.lowDone) begin
          stb.csHigh = 1'b1;
          stateNext  = ST_POLL;
        end
      end
      ST_POLL: begin
        if (st.timeout) begin
          stb.timerStop = 1'b1;
          stb.csLow     = 1'b1;
          errNext       = 1'b1;
          stateNext     = ST_IDLE;
        end else if (st.ready) begin
          stb.timerStop = 1'b1;
          stb.diHigh    = 1'b1;
          stb.divClr    = 1'b1;
          stateNext     = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        if (st.tick) begin
          if (!st.sckHigh) begin
            stb.sckRise = 1'b1;
          end else begin
            stb.sckFall = 1'b1;
            stb.csLow   = 1'b1;
            stb.diLow   = 1'b1;
            doneNext    = 1'b1;
            stateNext   = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
      err   <= errNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mw_erase_seq.sv
module mw_erase_seq
  import mwe_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int CLK_DIV     = 4,
  parameter int CS_LOW_CLKS = 25,
  parameter int POLL_LIMIT  = 2000,
  parameter int EARLY_START = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mwCs,
  output logic              mwSck,
  output logic              mwDi,
  input  logic              mwDo
);

  mweStrobe_t stb;
  mweStatus_t st;

  mwe_control #(.EARLY_START(EARLY_START)) uCtrl (
    .clk(clk), .rstN(rstN), .req(req), .st(st), .stb(stb),
    .busy(busy), .done(done), .err(err)
  );

  mwe_datapath #(
    .ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV),
    .CS_LOW_CLKS(CS_LOW_CLKS), .POLL_LIMIT(POLL_LIMIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .addr(addr), .mwDo(mwDo), .stb(stb), .st(st),
    .mwCs(mwCs), .mwSck(mwSck), .mwDi(mwDi)
  );

endmodule

// File: rtl/mwe_chk.sv
module mwe_chk #(
  parameter int CS_LOW_CLKS = 25
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic err,
  input logic mwCs,
  input logic mwSck,
  input logic mwDi
);

  logic [15:0] csLowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                csLowRun <= '0;
    else if (mwCs)                            csLowRun <= '0;
    else if (csLowRun != 16'(CS_LOW_CLKS))    csLowRun <= csLowRun + 1'b1;
  end

  // R3: status rise of chip select only after the minimum low time
  a_r3_cs_low_min: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mwCs) && $past(busy)) |-> (csLowRun >= 16'(CS_LOW_CLKS)));

  // R9: serial clock parked low while deselected
  a_r9_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !mwCs |-> !mwSck);

  // R2: data held steady while serial clock is high
  a_r2_di_stable_sck_high: assert property (@(posedge clk) disable iff (!rstN)
    mwSck |-> $stable(mwDi));

  // R10: outcomes exclusive and single-cycle
  a_r10_done_err_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    err |=> !err);

  // R7: busy ends only with an outcome
  a_r7_busy_ends_with_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || err));
  a_r7_outcome_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |-> ($past(busy) && !busy));

endmodule

bind mw_erase_seq mwe_chk #(.CS_LOW_CLKS(CS_LOW_CLKS)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err),
  .mwCs(mwCs), .mwSck(mwSck), .mwDi(mwDi)
);

// File: tb/sim_mw_erase_seq.sv
module mwe_dev_model (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cs,
  input  logic        sck,
  input  logic        di,
  input  int          busyClks,
  output logic        dout,
  output int          frames,
  output logic [31:0] lastFrame,
  output int          lastBits,
  output int          lastLow,
  output int          cleared,
  output logic        ready,
  output int          gapMin,
  output int          gapMax,
  output int          diViol,
  output int          sckViol
);
  logic        prevCs, prevSck, prevDi, phase, startSeen;
  logic [31:0] shreg;
  int          bits, busyCnt, lowRun, gapCnt;

  always @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs <= 0; prevSck <= 0; prevDi <= 0; phase <= 0; startSeen <= 0;
      shreg <= 0; bits <= 0; busyCnt <= 0; lowRun <= 0; gapCnt <= 0;
      frames <= 0; lastFrame <= 0; lastBits <= 0; lastLow <= 0; cleared <= 0;
      ready <= 0; gapMin <= 100000; gapMax <= 0; diViol <= 0; sckViol <= 0;
    end else begin
      prevCs <= cs; prevSck <= sck; prevDi <= di;
      if (sck && prevSck && di != prevDi) diViol <= diViol + 1;
      if (!cs && sck) sckViol <= sckViol + 1;
      if (sck && !prevSck) begin
        gapCnt <= 1;
        if (cs && !phase && bits > 0) begin
          if (gapCnt < gapMin) gapMin <= gapCnt;
          if (gapCnt > gapMax) gapMax <= gapCnt;
        end
      end else gapCnt <= gapCnt + 1;
      if (!cs) lowRun <= lowRun + 1;
      else lowRun <= 0;
      if (cs && !prevCs && phase) lastLow <= lowRun;
      if (!phase) begin
        if (cs && sck && !prevSck) begin
          shreg <= {shreg[30:0], di};
          bits  <= bits + 1;
        end
        if (!cs && prevCs && bits > 0) begin
          lastFrame <= shreg; lastBits <= bits; frames <= frames + 1;
          bits <= 0; shreg <= 0; phase <= 1; busyCnt <= busyClks; ready <= 0;
        end
      end else begin
        if (busyCnt > 0) busyCnt <= busyCnt - 1;
        else ready <= 1;
        if (cs && sck && !prevSck && di) startSeen <= 1;
        if (!cs && prevCs && startSeen) begin
          cleared <= cleared + 1; phase <= 0; startSeen <= 0;
        end
      end
    end
  end

  assign dout = cs && phase && ready;
endmodule

module sim_mw_erase_seq;
  localparam int CLK_DIV = 4, CS_LOW = 25, LIMIT = 2000;

  logic clk = 0, rstN = 0;
  always #5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit finished = 0;

  // instance 0: standard variant
  logic       req0 = 0; logic [5:0] addr0 = 0;
  logic       busy0, done0, err0, cs0, sck0, di0, do0;
  int         bc0 = 100;
  int         fr0, lb0, ll0, cl0, gmin0, gmax0, dv0, sv0;
  logic [31:0] lf0; logic rdy0;

  mw_erase_seq u0 (
    .clk(clk), .rstN(rstN), .req(req0), .addr(addr0), .busy(busy0), .done(done0),
    .err(err0), .mwCs(cs0), .mwSck(sck0), .mwDi(di0), .mwDo(do0)
  );
  mwe_dev_model m0 (
    .clk(clk), .rstN(rstN), .cs(cs0), .sck(sck0), .di(di0), .busyClks(bc0),
    .dout(do0), .frames(fr0), .lastFrame(lf0), .lastBits(lb0), .lastLow(ll0),
    .cleared(cl0), .ready(rdy0), .gapMin(gmin0), .gapMax(gmax0), .diViol(dv0),
    .sckViol(sv0)
  );

  // instance 1: alternate variant, 7-bit address
  logic       req1 = 0; logic [6:0] addr1 = 0;
  logic       busy1, done1, err1, cs1, sck1, di1, do1;
  int         bc1 = 100;
  int         fr1, lb1, ll1, cl1, gmin1, gmax1, dv1, sv1;
  logic [31:0] lf1; logic rdy1;

  mw_erase_seq #(.ADDR_W(7), .EARLY_START(1)) u1 (
    .clk(clk), .rstN(rstN), .req(req1), .addr(addr1), .busy(busy1), .done(done1),
    .err(err1), .mwCs(cs1), .mwSck(sck1), .mwDi(di1), .mwDo(do1)
  );
  mwe_dev_model m1 (
    .clk(clk), .rstN(rstN), .cs(cs1), .sck(sck1), .di(di1), .busyClks(bc1),
    .dout(do1), .frames(fr1), .lastFrame(lf1), .lastBits(lb1), .lastLow(ll1),
    .cleared(cl1), .ready(rdy1), .gapMin(gmin1), .gapMax(gmax1), .diViol(dv1),
    .sckViol(sv1)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (40) @(negedge clk);
  endtask

  // run one erase on u0; optional stray request injected mid-operation
  task automatic runOp0(input logic [5:0] a, input bit inject, output int csFall,
                        output int endCyc, output bit gotDone, output bit gotErr,
                        output bit rdyAtDone, output int busyDrops);
    bit prevCs = 0;
    csFall = -1; endCyc = -1; gotDone = 0; gotErr = 0; rdyAtDone = 0; busyDrops = 0;
    @(negedge clk) req0 = 1; addr0 = a;
    @(negedge clk) req0 = 0;
    prevCs = cs0;
    check(busy0 == 1, "R7 busy after req", busy0, 1);
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (inject && i == 100) begin req0 = 1; addr0 = ~a; end
      else req0 = 0;
      if (prevCs && !cs0 && csFall < 0) csFall = cyc;
      prevCs = cs0;
      if (done0 || err0) begin
        gotDone = done0; gotErr = err0; endCyc = cyc; rdyAtDone = rdy0;
        break;
      end
      if (!busy0) busyDrops++;
    end
    req0 = 0;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    check(cs0 == 0, "R8 cs after reset", cs0, 0);
    check(sck0 == 0, "R8 sck after reset", sck0, 0);
    check(di0 == 0, "R8 di after reset", di0, 0);
    check(busy0 == 0 && done0 == 0 && err0 == 0, "R8 flags after reset",
          {busy0, done0, err0}, 0);
  endtask

  task automatic t_erase(input logic [5:0] a, input int busyTime, input bit inject);
    int csF, endC, drops, frBefore, clBefore;
    bit gd, ge, rd;
    bc0 = busyTime;
    frBefore = fr0; clBefore = cl0;
    runOp0(a, inject, csF, endC, gd, ge, rd, drops);
    check(fr0 == frBefore + 1, "R7 exactly one frame sent", fr0 - frBefore, 1);
    check(lb0 == 9, "R1 frame length", lb0, 9);
    check(lf0[8:0] == {3'b111, a}, "R1 frame content", lf0[8:0], {3'b111, a});
    check(gmin0 == 2 * CLK_DIV && gmax0 == 2 * CLK_DIV, "R2 sck period",
          gmin0, 2 * CLK_DIV);
    check(dv0 == 0, "R2 di stable while sck high", dv0, 0);
    check(sv0 == 0, "R9 sck low while cs low", sv0, 0);
    check(ll0 == CS_LOW, "R3 cs low time", ll0, CS_LOW);
    check(gd && !ge, "R10 done without err", {gd, ge}, 2);
    check(rd == 1, "R4 device ready before done", rd, 1);
    check(endC - csF > busyTime, "R4 done after busy period", endC - csF, busyTime + 1);
    check(cl0 == clBefore + 1, "R5 status cleared by start bit", cl0 - clBefore, 1);
    check(drops == 0, "R7 busy held through operation", drops, 0);
  endtask

  task automatic t_timeout0();
    int csF, endC, drops, clBefore;
    bit gd, ge, rd;
    bc0 = 1000000;
    clBefore = cl0;
    runOp0(6'h15, 0, csF, endC, gd, ge, rd, drops);
    check(ge && !gd, "R6 err without done", {gd, ge}, 1);
    check(endC - csF == LIMIT, "R6 std timeout from cs fall", endC - csF, LIMIT);
    check(cl0 == clBefore, "R6 no clear on timeout", cl0 - clBefore, 0);
    check(cs0 == 0, "R9 cs low after timeout", cs0, 0);
    doReset();
  endtask

  task automatic runOp1(input logic [6:0] a, input int busyTime, input bit expectErr);
    int csF = -1, endC = -1;
    bit prevCs = 0, gd = 0, ge = 0;
    bc1 = busyTime;
    @(negedge clk) req1 = 1; addr1 = a;
    @(negedge clk) req1 = 0;
    prevCs = cs1;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (prevCs && !cs1 && csF < 0) csF = cyc;
      prevCs = cs1;
      if (done1 || err1) begin gd = done1; ge = err1; endC = cyc; break; end
    end
    check(lb1 == 10, "R1 alt frame length", lb1, 10);
    check(lf1[9:0] == {3'b111, a}, "R1 alt frame content", lf1[9:0], {3'b111, a});
    if (expectErr) begin
      check(ge && !gd, "R6 alt err", {gd, ge}, 1);
      check(endC - csF == LIMIT - CLK_DIV, "R6 alt timeout from last rising edge",
            endC - csF, LIMIT - CLK_DIV);
    end else begin
      check(gd && !ge, "R5 alt done", {gd, ge}, 2);
      check(ll1 == CS_LOW, "R3 alt cs low time", ll1, CS_LOW);
    end
    repeat (40) @(negedge clk);
  endtask

  initial begin
    doReset();
    t_reset();
    t_erase(6'h2A, 300, 0);
    t_erase(6'h00, 2, 0);
    t_erase(6'h3F, 800, 1);
    t_timeout0();
    runOp1(7'h55, 1000000, 1);
    doReset();
    runOp1(7'h7F, 200, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule